// File: doc/BRIEF.md
# Instrument Operating Mode Manager

This block holds the operating mode of an instrument suite and turns that mode into one power-request line per instrument. The switch controller that sits behind these lines is not part of the block. There are four modes: safe, engineering, low power and nominal science. Three sources can request a mode change: ground commands, an automatic low-power request from the spacecraft bus, and an undervoltage alarm. Reset puts the block in safe mode.

When the block enters nominal mode, it requests instruments in ascending index order, one at a time. It waits a programmable settle interval between one request and the next. When it enters low power mode, it drops every instrument request except the magnetometer's and keeps that one asserted. An undervoltage alarm takes priority over every other source and abandons any power-up sequence in progress.

Top module: `inst_mode_mgr`

## Requirements
- R1: While reset is asserted and after it is released, `mode_o` is 2'b00 (safe), `pwr_req_o` is all zero and `seq_busy_o` is low.
- R2: Mode codes are safe=00, engineering=01, low power=10, nominal=11. A ground command (`cmd_valid_i` with `cmd_mode_i`=00) moves the block to safe at the next clock edge, and all of `pwr_req_o` clears at that same edge.
- R3: Only a ground command with code 01 can enter engineering mode. Entering it leaves `pwr_req_o` exactly as it was.
- R4: Low power mode is entered by a ground command with code 10 or by `bus_lowpwr_i`. At the entry edge, `pwr_req_o` becomes exactly the one-hot bit MAG_IDX.
- R5: When nominal mode is entered (ground code 11) at edge E with settle value S, instrument k is requested at edge E + k*(S+1), for k = 0 to NUM_INST-1. A request, once set, stays set while the block is in nominal mode. Bits that were already set on entry stay set.
- R6: `uv_alarm_i` forces safe mode and an all-zero `pwr_req_o` at the next edge, from any mode, including partway through a sequence. No further request is raised after that.
- R7: When several sources are active in the same cycle, priority runs undervoltage first, then the bus low-power request, then the ground command.
- R8: A request for the mode the block is already in has no effect. It does not restart the sequence and does not change `pwr_req_o`.
- R9: Leaving nominal mode for engineering partway through a sequence stops the sequence. The requests raised so far are held.
- R10: `seq_busy_o` is high from the edge that enters nominal mode until the edge that raises the last instrument request. It falls at that last edge, or at the edge that leaves nominal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Ground mode command strobe |
| cmd_mode_i | input | 2 | Commanded mode code |
| bus_lowpwr_i | input | 1 | Automatic low-power request from the spacecraft bus |
| uv_alarm_i | input | 1 | Undervoltage alarm |
| settle_cycles_i | input | SETTLE_W | Settle interval between successive power-up requests |
| mode_o | output | 2 | Current mode code |
| pwr_req_o | output | NUM_INST | Per-instrument power request |
| seq_busy_o | output | 1 | Power-up sequence in progress |

## Verification
The hardest situations to reach are the ones where a mode change lands in the middle of a power-up sequence, after some requests are up and before the rest. To reach them, the bench enters nominal mode with a long settle value. It counts edges from entry so that it knows exactly how many requests are up, then fires undervoltage or an engineering command at that point. It then checks over many further cycles that no new request appears. The settle values are swept over the whole range of a narrow settle field, and every cycle of each sequence is compared against the edge times worked out from R5.

// File: rtl/imm_pkg.sv
package imm_pkg;
  typedef enum logic [1:0] {
    MODE_SAFE = 2'b00,
    MODE_ENG  = 2'b01,
    MODE_LOW  = 2'b10,
    MODE_NOM  = 2'b11
  } op_mode_e;
endpackage

// File: rtl/mode_arb.sv
module mode_arb
  import imm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_valid_i,
  input  logic [1:0] cmd_mode_i,
  input  logic     bus_lowpwr_i,
  input  logic     uv_alarm_i,
  output op_mode_e mode_o,
  output op_mode_e tgt_o,
  output logic     enter_o
);
  op_mode_e mode_q;
  op_mode_e tgt;
  logic     req;

  // fixed priority: undervoltage, bus, ground
  always_comb begin
    req = 1'b1;
    tgt = mode_q;
    if (uv_alarm_i)        tgt = MODE_SAFE;
    else if (bus_lowpwr_i) tgt = MODE_LOW;
    else if (cmd_valid_i)  tgt = op_mode_e'(cmd_mode_i);
    else                   req = 1'b0;
  end

  assign enter_o = req && (tgt != mode_q);
  assign tgt_o   = tgt;
  assign mode_o  = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_SAFE;
    else if (enter_o) mode_q <= tgt;
  end

  a_r6_uv_to_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_alarm_i |=> mode_q == MODE_SAFE);
  a_r7_bus_over_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lowpwr_i && !uv_alarm_i) |=> mode_q == MODE_LOW);
  a_r3_eng_by_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_ENG && $past(mode_q) != MODE_ENG) |->
      $past(cmd_valid_i && cmd_mode_i == 2'b01 && !bus_lowpwr_i && !uv_alarm_i));
endmodule

// File: rtl/power_seq.sv
module power_seq #(
  parameter int NUM_INST = 4,
  parameter int SETTLE_W = 8,
  localparam int IDX_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                abort_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                step_o,
  output logic [IDX_W-1:0]    step_idx_o,
  output logic                busy_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_INST - 1);

  logic [IDX_W-1:0]    idx_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic                busy_q;

  assign step_o     = busy_q && (cnt_q == '0) && !abort_i && !start_i;
  assign step_idx_o = idx_q;
  assign busy_o     = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      idx_q  <= IDX_W'(1);
      cnt_q  <= settle_i;
      busy_q <= (NUM_INST > 1);
    end else if (abort_i) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        cnt_q <= settle_i;
        idx_q <= idx_q + IDX_W'(1);
        if (idx_q == LAST_IDX) busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - SETTLE_W'(1);
      end
    end
  end

  a_r5_step_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (idx_q <= LAST_IDX && idx_q != '0));
  a_r10_busy_drops_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && idx_q == LAST_IDX) |=> !busy_q);
endmodule

// File: rtl/pwr_reg.sv
module pwr_reg
  import imm_pkg::*;
#(
  parameter int NUM_INST = 4,
  parameter int MAG_IDX  = 0,
  localparam int IDX_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enter_i,
  input  op_mode_e            tgt_i,
  input  logic                step_i,
  input  logic [IDX_W-1:0]    step_idx_i,
  output logic [NUM_INST-1:0] pwr_o
);
  localparam logic [NUM_INST-1:0] MAG_MASK   = NUM_INST'(1) << MAG_IDX;
  localparam logic [NUM_INST-1:0] FIRST_MASK = NUM_INST'(1);

  logic [NUM_INST-1:0] pwr_q, pwr_d;

  always_comb begin
    pwr_d = pwr_q;
    if (enter_i) begin
      unique case (tgt_i)
        MODE_SAFE: pwr_d = '0;
        MODE_LOW:  pwr_d = MAG_MASK;
        MODE_NOM:  pwr_d = pwr_q | FIRST_MASK;
        default:   pwr_d = pwr_q;
      endcase
    end else if (step_i) begin
      pwr_d = pwr_q | (NUM_INST'(1) << step_idx_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwr_q <= '0;
    else         pwr_q <= pwr_d;
  end

  assign pwr_o = pwr_q;
endmodule

// File: rtl/inst_mode_mgr.sv
module inst_mode_mgr
  import imm_pkg::*;
#(
  parameter int NUM_INST = 5,
  parameter int MAG_IDX  = 0,
  parameter int SETTLE_W = 16,
  localparam int IDX_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_mode_i,
  input  logic                bus_lowpwr_i,
  input  logic                uv_alarm_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  output logic [1:0]          mode_o,
  output logic [NUM_INST-1:0] pwr_req_o,
  output logic                seq_busy_o
);
  localparam logic [NUM_INST-1:0] MAG_MASK = NUM_INST'(1) << MAG_IDX;

  op_mode_e         mode, tgt;
  logic             enter, start, abort, step;
  logic [IDX_W-1:0] step_idx;

  mode_arb i_arb (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_mode_i, .bus_lowpwr_i, .uv_alarm_i,
    .mode_o(mode), .tgt_o(tgt), .enter_o(enter)
  );

  assign start = enter && (tgt == MODE_NOM);
  assign abort = enter && (tgt != MODE_NOM);

  power_seq #(.NUM_INST(NUM_INST), .SETTLE_W(SETTLE_W)) i_seq (
    .clk_i, .rst_ni, .start_i(start), .abort_i(abort), .settle_i(settle_cycles_i),
    .step_o(step), .step_idx_o(step_idx), .busy_o(seq_busy_o)
  );

  pwr_reg #(.NUM_INST(NUM_INST), .MAG_IDX(MAG_IDX)) i_pwr (
    .clk_i, .rst_ni, .enter_i(enter), .tgt_i(tgt), .step_i(step),
    .step_idx_i(step_idx), .pwr_o(pwr_req_o)
  );

  assign mode_o = mode;

  a_r2_safe_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_SAFE |-> (pwr_req_o == '0 && !seq_busy_o));
  a_r4_low_mag_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_LOW |-> pwr_req_o == MAG_MASK);
  a_r5_one_new_per_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(pwr_req_o & ~$past(pwr_req_o)) <= 1);
  a_r5_nom_no_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_NOM && $past(mode) == MODE_NOM) |->
      (pwr_req_o & $past(pwr_req_o)) == $past(pwr_req_o));
  a_r10_busy_only_nom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_busy_o |-> mode == MODE_NOM);
endmodule

// File: tb/test_inst_mode_mgr.sv
module test_inst_mode_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int MAG = 2;
  localparam int SW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_mode = 2'b00;
  logic          bus_lp = 1'b0;
  logic          uv = 1'b0;
  logic [SW-1:0] settle = '0;
  logic [1:0]    mode;
  logic [N-1:0]  pwr;
  logic          busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inst_mode_mgr #(.NUM_INST(N), .MAG_IDX(MAG), .SETTLE_W(SW)) i_inst_mode_mgr (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_mode_i(cmd_mode),
    .bus_lowpwr_i(bus_lp), .uv_alarm_i(uv), .settle_cycles_i(settle),
    .mode_o(mode), .pwr_req_o(pwr), .seq_busy_o(busy)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic state(input int m, input int p, input int b, input string req);
    chk(mode, m, req);
    chk(pwr, p, req);
    chk(busy, b, req);
  endtask

  // drive on a low phase, let one edge take it, return at the next low phase
  task automatic issue(input bit v, input int m, input bit b, input bit u);
    cmd_valid = v; cmd_mode = 2'(m); bus_lp = b; uv = u;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; bus_lp = 1'b0; uv = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic int seq_mask(input int t, input int s, input int base);
    int m = base;
    for (int k = 0; k < N; k++) if (k * (s + 1) <= t) m |= (1 << k);
    return m;
  endfunction

  localparam int MAGM = 1 << MAG;
  localparam int ALL  = (1 << N) - 1;

  initial begin
    repeat (3) @(negedge clk);
    state(0, 0, 0, "R1 in reset");
    rst_n = 1'b1;
    tick(1);
    state(0, 0, 0, "R1 after reset");

    issue(1, 1, 0, 0);
    state(1, 0, 0, "R3 enter eng from safe");
    issue(1, 0, 0, 0);
    state(0, 0, 0, "R2 ground safe");
    issue(1, 2, 0, 0);
    state(2, MAGM, 0, "R4 ground low");
    issue(1, 2, 0, 0);
    state(2, MAGM, 0, "R8 repeat low");
    issue(0, 0, 1, 0);
    state(2, MAGM, 0, "R8 bus low while low");

    // R5/R10 sweep every settle value, from safe
    for (int s = 0; s < (1 << SW); s++) begin
      issue(1, 0, 0, 0);
      settle = SW'(s);
      issue(1, 3, 0, 0);
      for (int t = 0; t <= (N - 1) * (s + 1) + 2; t++) begin
        chk(mode, 3, "R5 mode nom");
        chk(pwr, seq_mask(t, s, 0), "R5 sequence mask");
        chk(busy, (t < (N - 1) * (s + 1)) ? 1 : 0, "R10 busy window");
        tick(1);
      end
      issue(1, 3, 0, 0);
      state(3, ALL, 0, "R8 repeat nom");
    end

    // R5 from low: magnetometer bit kept
    settle = SW'(1);
    issue(1, 2, 0, 0);
    issue(1, 3, 0, 0);
    for (int t = 0; t <= (N - 1) * 2 + 1; t++) begin
      chk(pwr, seq_mask(t, 1, MAGM), "R5 from low mask");
      tick(1);
    end

    // R3: engineering from full nominal keeps set
    issue(1, 1, 0, 0);
    state(1, ALL, 0, "R3 eng keeps power");

    // R9: leave mid-sequence to eng
    settle = SW'(3);
    issue(1, 0, 0, 0);
    issue(1, 3, 0, 0);
    tick(4);
    chk(pwr, 3, "R9 partial before leave");
    issue(1, 1, 0, 0);
    state(1, 3, 0, "R9 eng frozen");
    tick(12);
    state(1, 3, 0, "R9 no later request");

    // R6: undervoltage mid-sequence
    issue(1, 0, 0, 0);
    issue(1, 3, 0, 0);
    tick(4);
    issue(0, 0, 0, 1);
    state(0, 0, 0, "R6 uv mid-sequence");
    tick(12);
    state(0, 0, 0, "R6 no later request");

    // R7 priority
    issue(1, 3, 1, 1);
    state(0, 0, 0, "R7 uv beats all");
    issue(1, 3, 1, 0);
    state(2, MAGM, 0, "R7 bus beats cmd");
    issue(1, 3, 0, 0);
    tick(10);
    issue(0, 0, 1, 0);
    state(2, MAGM, 0, "R4 bus low from nom");
    issue(1, 1, 0, 1);
    state(0, 0, 0, "R7 uv beats eng cmd");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule